// File: doc/BRIEF.md
# Serial Configuration Register Read Port

This block is the slave side of a serial link. It answers one command: a read of a small configuration register. The block samples the serial clock, chip select and serial data input with the system clock. It then decodes the frame bit by bit on rising serial clock edges. A valid frame has four parts in this order:

- an 8-bit opcode;
- two 16-bit address fields that must both be zero;
- sixteen control clocks.

After that the block drives a 32-bit response on the serial output, most significant bit first. The response is a 16-bit ready/busy status word followed by a 16-bit configuration word. Output bits change after falling serial clock edges. An output-enable signal stands in for a high-impedance pin.

The configuration register holds nine bits: a hold/ready-busy pin mode bit, a read-edge select bit, a 4-bit write-protect range and a 3-bit alternate oscillator select. The upper seven bits of the 16-bit word are reserved. The register can be written directly from the system side, so that test can set a known value before reading it back over the serial link. What the configuration bits do is handled elsewhere.

Top module: `cfgrd_port`

## Requirements
- R1: While `cs_n` is low, each rising `sck` edge takes one bit of `si`. The first eight bits, most significant first, must be the opcode 8Bh (10001011b).
- R2: Bits 8 to 39 of the frame (the sector and byte address fields) must all be 0. If any of them is 1, the block drives no output for the rest of that frame.
- R3: If the opcode differs from 8Bh, the block drives no output for the rest of that frame.
- R4: In a valid frame, bits 40 to 55 are control clocks whose data is ignored. After the falling `sck` edge that follows rising edge 56, the block drives response bit 31. After each later falling edge it drives the next lower bit, down to bit 0 after the falling edge that follows rising edge 87.
- R5: Response bits 31:16 are the status word. Bit 31 is 1 when the `busy` input is low and 0 when it is high. Bits 30:16 are 0.
- R6: Response bits 15:0 are the configuration word. Bits 8:0 are the register value: bit 0 is the pin mode, bit 1 the read-edge select, bits 5:2 the write-protect range and bits 8:6 the oscillator select. Bits 15:9 are 0.
- R7: `so_en` is low, and `so` is 0, whenever `cs_n` is high. They are also low and 0 before the first response bit and after the falling edge that follows rising edge 88.
- R8: `cs_n` going high at any point clears the bit count and the command state, so the next frame is decoded from scratch. If `cs_n` rises as `sck` falls, the chip-select rise wins and no output is driven.
- R9: `cfg_load` high at a `clk` edge writes `cfg_wdata` into the register, and `cfg_q` shows the new value on the next cycle. The response takes a copy of the register and of `busy` when it drives the first status bit.
- R10: While `rst_n` is low, a `clk` edge sets `so_en` low, `so` to 0 and the register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| busy | input | 1 | Device busy flag reported in the status word |
| cfg_load | input | 1 | Test write strobe for the configuration register |
| cfg_wdata | input | 9 | Value written by `cfg_load` |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output drive enable (low means high impedance) |
| cfg_q | output | 9 | Current configuration register value |

## Verification
Two events can land in the same system clock cycle: a chip-select rise and the falling serial edge that would start the response. The bench provokes this by running a valid frame up to its 56th rising edge. It then drops `sck` and raises `cs_n` in the same step, so both pass through equal synchronizer depths and reach the sequencer together. The case is judged by watching `so_en` for the following cycles: it must never go high. A complete valid frame must then read back correctly, which shows that the abandoned frame left no count behind.

// File: rtl/cfgrd_pkg.sv
// Package: shared constants and types for the configuration read port.
// Assumes a fixed frame layout: opcode, zero address, control clocks, response.
package cfgrd_pkg;
    localparam int        OPC_BITS   = 8;
    localparam logic [7:0] RD_OPCODE = 8'h8B;
    localparam int        ADDR_BITS  = 32;
    localparam int        CTRL_CLKS  = 16;
    localparam int        WORD_BITS  = 16;
    localparam int        CFG_BITS   = 9;

    localparam int        ADDR_END   = OPC_BITS + ADDR_BITS;
    localparam int        DATA_START = ADDR_END + CTRL_CLKS;
    localparam int        RESP_BITS  = 2 * WORD_BITS;
    localparam int        DATA_END   = DATA_START + RESP_BITS;
    localparam int        CNT_W      = $clog2(DATA_END + 1);
    localparam int        RSV_BITS   = WORD_BITS - CFG_BITS;

    typedef struct packed {
        logic [2:0] osc_sel;
        logic [3:0] wp_range;
        logic       edge_sel;
        logic       pin_mode;
    } cfg_t;
endpackage

// File: rtl/cfgrd_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes STAGES >= 1; the reset value sets each pin's idle level.
module cfgrd_sync #(
    parameter int             STAGES  = 2,
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            // Purpose: single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= RST_VAL;
                else        stg <= d;
            end
        end else begin : g_many
            // Purpose: shift the pins through a chain of stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgrd_frame.sv
// Module: frame sequencer. Counts rising serial edges, checks the opcode and
// the all-zero address fields, and flags a frame that failed a check.
// Assumes rise and cs_high come from synchronized pins.
module cfgrd_frame
    import cfgrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_high,
    input  logic             rise,
    input  logic             si_s,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_ok
);
    logic [OPC_BITS-1:0] opc_sh;
    logic                bad;
    logic                in_opc;
    logic                in_addr;

    assign in_opc  = (cnt < CNT_W'(OPC_BITS));
    assign in_addr = !in_opc && (cnt < CNT_W'(ADDR_END));

    // Purpose: bit counter, saturating at the end of the response.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_high)
            cnt <= '0;
        else if (rise && cnt != CNT_W'(DATA_END))
            cnt <= cnt + 1'b1;
    end

    // Purpose: hold the expected opcode and step it one bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_high)
            opc_sh <= RD_OPCODE;
        else if (rise && in_opc)
            opc_sh <= {opc_sh[OPC_BITS-2:0], 1'b0};
    end

    // Purpose: latch a failed check until chip select goes high.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_high)
            bad <= 1'b0;
        else if (rise && in_opc && (si_s != opc_sh[OPC_BITS-1]))
            bad <= 1'b1;
        else if (rise && in_addr && si_s)
            bad <= 1'b1;
    end

    assign frame_ok = !bad;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> cnt == '0);                                                // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !cs_high && cnt < CNT_W'(DATA_END)) |=> cnt == $past(cnt) + 1'b1); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DATA_END));                                              // R4
endmodule

// File: rtl/cfgrd_shift.sv
// Module: response shifter. On the falling edge that opens the data phase of
// a valid frame it copies the response word, then drives one bit per falling edge.
// Assumes fall, cs_high and cnt are aligned to the same system clock.
module cfgrd_shift
    import cfgrd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_high,
    input  logic                 fall,
    input  logic [CNT_W-1:0]     cnt,
    input  logic                 frame_ok,
    input  logic [RESP_BITS-1:0] word,
    output logic                 so,
    output logic                 so_en,
    output logic                 snap
);
    logic [RESP_BITS-1:0] sh;

    assign snap = fall && !cs_high && frame_ok && (cnt == CNT_W'(DATA_START));

    // Purpose: load, shift and release the serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            so    <= 1'b0;
            so_en <= 1'b0;
        end else if (cs_high) begin
            so    <= 1'b0;
            so_en <= 1'b0;
        end else if (fall) begin
            if (snap) begin
                sh    <= {word[RESP_BITS-2:0], 1'b0};
                so    <= word[RESP_BITS-1];
                so_en <= 1'b1;
            end else if (so_en && cnt < CNT_W'(DATA_END)) begin
                sh    <= {sh[RESP_BITS-2:0], 1'b0};
                so    <= sh[RESP_BITS-1];
            end else begin
                so    <= 1'b0;
                so_en <= 1'b0;
            end
        end
    end

    AST_QUIET_IF_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_ok && !so_en) |=> !so_en);                                     // R3
    AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_high) |=> ($stable(so) && $stable(so_en)));              // R4
endmodule

// File: rtl/cfgrd_port.sv
// Module: top of the configuration read port. Synchronizes the serial pins,
// finds clock edges, holds the configuration register and builds the response.
// Assumes busy and the test write port are synchronous to clk.
module cfgrd_port
    import cfgrd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                cs_n,
    input  logic                si,
    input  logic                busy,
    input  logic                cfg_load,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    output logic                so,
    output logic                so_en,
    output logic [CFG_BITS-1:0] cfg_q
);
    logic [2:0]           pins_s;
    logic                 cs_s, sck_s, si_s, sck_d;
    logic                 rise, fall;
    logic [CNT_W-1:0]     cnt;
    logic                 frame_ok;
    logic                 snap;
    cfg_t                 cfg_r;
    logic [RESP_BITS-1:0] word;

    cfgrd_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign si_s  = pins_s[0];

    // Purpose: previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign rise = sck_s && !sck_d;
    assign fall = !sck_s && sck_d;

    // Purpose: configuration register with a direct test write.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_r <= '0;
        else if (cfg_load) cfg_r <= cfg_t'(cfg_wdata);
    end

    assign cfg_q = cfg_r;
    assign word  = {!busy, {(WORD_BITS-1){1'b0}}, {RSV_BITS{1'b0}}, cfg_r};

    cfgrd_frame u_frame (
        .clk(clk), .rst_n(rst_n), .cs_high(cs_s), .rise(rise), .si_s(si_s),
        .cnt(cnt), .frame_ok(frame_ok)
    );

    cfgrd_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_high(cs_s), .fall(fall), .cnt(cnt),
        .frame_ok(frame_ok), .word(word), .so(so), .so_en(so_en), .snap(snap)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!so_en && !so));                                             // R7
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cfg_q == $past(cfg_wdata));                               // R9
    AST_SNAP_STARTS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (so_en && so == $past(!busy)));                               // R5
endmodule

// File: tb/sim_cfgrd_port.sv
module sim_cfgrd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0, cfg_load = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       so, so_en;
    logic [8:0] cfg_q;

    int total = 0, bad = 0;
    logic last_so, last_en;

    always #5 clk = ~clk;

    cfgrd_port u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
                   .busy(busy), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata),
                   .so(so), .so_en(so_en), .cfg_q(cfg_q));

    // Vector: opcode(8) sector(16) byte(16) busy(1) cfg(9) ok(1)
    localparam logic [50:0] VEC [6] = '{
        {8'h8B, 16'h0000, 16'h0000, 1'b0, 9'h1FF, 1'b1},
        {8'h8B, 16'h0000, 16'h0000, 1'b1, 9'h0A5, 1'b1},
        {8'h8A, 16'h0000, 16'h0000, 1'b0, 9'h155, 1'b0},
        {8'h8B, 16'h8000, 16'h0000, 1'b0, 9'h155, 1'b0},
        {8'h8B, 16'h0000, 16'h0001, 1'b0, 9'h155, 1'b0},
        {8'h8B, 16'h0000, 16'h0000, 1'b0, 9'h100, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sck = 1'b0; si = b;
        repeat (4) @(negedge clk);
        last_so = so; last_en = so_en;
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_cfg(input logic [8:0] v);
        @(negedge clk); cfg_load = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] opc, input logic [15:0] sa, input logic [15:0] ba,
                             output logic [31:0] got, output int en_in, output int en_out);
        logic [55:0] cmd;
        cmd = {opc, sa, ba, 16'h0};
        got = '0; en_in = 0; en_out = 0;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 90; k++) begin
            send_bit(k < 56 ? cmd[55-k] : 1'b0);
            if (last_en) begin
                if (k >= 56 && k < 88) begin
                    got[31-(k-56)] = last_so;
                    en_in++;
                end else en_out++;
            end
        end
        sck = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] got, exp;
        int ein, eout, seen;
        repeat (4) @(negedge clk);
        // R10: reset state
        check(so_en == 0 && so == 0 && cfg_q == 0, "R10", {so_en, so, cfg_q}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: direct write visible on cfg_q
        load_cfg(9'h0C3);
        check(cfg_q == 9'h0C3, "R9", cfg_q, 9'h0C3);

        // Table: R1..R6 over distinct frames
        for (int i = 0; i < 6; i++) begin
            logic [50:0] v;
            v = VEC[i];
            load_cfg(v[9:1]);
            busy = v[10];
            run_frame(v[50:43], v[42:27], v[26:11], got, ein, eout);
            exp = v[0] ? {~v[10], 15'b0, 7'b0, v[9:1]} : 32'h0;
            check(got == exp, v[0] ? "R4/R5/R6 data" : "R2/R3 no data", got, exp);
            check(ein == (v[0] ? 32 : 0), "R1/R3 enable count", ein, v[0] ? 32 : 0);
            check(eout == 0, "R7 enable outside window", eout, 0);
        end
        busy = 1'b0;

        // R7: clocks with chip select high produce no output
        seen = 0;
        cs_n = 1'b1;
        for (int k = 0; k < 90; k++) begin
            send_bit(k < 8 ? 1'b1 : 1'b0);
            if (last_en) seen++;
        end
        sck = 1'b0;
        check(seen == 0, "R7 cs high", seen, 0);

        // R8: abort inside the response, then a clean frame
        load_cfg(9'h03C);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 62; k++) send_bit(k < 8 ? 8'h8B >> (7 - k) : 1'b0);
        check(last_en == 1'b1, "R4 mid response enabled", last_en, 1);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        check(so_en == 0 && so == 0, "R8/R7 abort release", {so_en, so}, 0);
        run_frame(8'h8B, 16'h0, 16'h0, got, ein, eout);
        check(got == {1'b1, 15'b0, 16'h003C}, "R8 after abort", got, {1'b1, 15'b0, 16'h003C});

        // R8: cs rise together with the falling edge that would start output
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 56; k++) send_bit(k < 8 ? 8'h8B >> (7 - k) : 1'b0);
        sck = 1'b0; cs_n = 1'b1;
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (so_en) seen++;
        end
        check(seen == 0, "R8 cs wins over falling edge", seen, 0);
        run_frame(8'h8B, 16'h0, 16'h0, got, ein, eout);
        check(got == {1'b1, 15'b0, 16'h003C} && ein == 32, "R8 clean after collision", got, {1'b1, 15'b0, 16'h003C});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule